// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block makes faults and external interrupts precise in a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It keeps a small tag record for each instruction in flight: whether it is valid, its PC, whether it wants a memory write or a register write, and whether it has faulted and why. A fault is recorded in the stage that detects it and travels down the pipe with its instruction. Nothing acts on it until the instruction reaches the memory stage. Memory writes happen in the memory stage and register writes in write-back, so deferring the decision to that point means every older instruction has already committed and no younger one has.

When the instruction in the memory stage carries a fault, or the interrupt line is high while that stage holds a valid instruction, the controller takes the exception in that cycle. It blocks that instruction's memory write and discards it and every younger instruction. It steers fetch to a fixed handler vector in the same cycle. At the next edge it loads the faulting PC and a cause code into the saved-PC and cause registers. An interrupt is attached to the instruction in the memory stage, so the saved PC names that instruction and it runs again on return. A return request steers fetch back to the saved PC.

Top module: `precExcCommit`

## Requirements
- R1: After reset every stage is empty, memWrEn, regWrEn and redirect are 0, and epc and cause are 0.
- R2: A fault-free instruction presented at the fetch inputs in cycle t drives memWrEn with memWrPc equal to its PC in cycle t+3 if ifMemWr was set, and regWrEn with regWrPc equal to its PC in cycle t+4 if ifRegWr was set.
- R3: An instruction flagged by idUndef while in decode (cycle t+1) is taken in cycle t+3: redirect is 1 with redirectPc equal to HANDLER_VEC. From cycle t+4 epc holds its PC and cause holds code 1.
- R4: An instruction flagged by exArith while in execute (cycle t+2) is taken in cycle t+3 in the same way, with cause code 2.
- R5: When an exception is taken, neither the taken instruction nor any younger one produces memWrEn or regWrEn. This covers the instructions in decode and execute, and the one being fetched in that cycle.
- R6: An instruction older than the taken one still completes its register write, even in the cycle the exception is taken.
- R7: When faults are flagged on two instructions in the same cycle, only the older one is reported in epc and cause.
- R8: An instruction flagged in both decode and execute keeps the first cause it received (code 1).
- R9: A high irqReq is taken on the instruction in the memory stage with cause code 0, and epc equal to that instruction's PC. While that stage is empty, the request waits and no redirect occurs.
- R10: If the instruction in the memory stage has a fault while irqReq is high, the fault's cause code is reported, not code 0.
- R11: epc and cause keep their values in every cycle in which no exception is taken.
- R12: eretReq makes redirect 1 with redirectPc equal to epc in the same cycle, and discards the instruction fetched in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ifValid | input | 1 | A fetched instruction is present this cycle |
| ifPc | input | PC_W | PC of the fetched instruction |
| ifMemWr | input | 1 | Fetched instruction will write memory |
| ifRegWr | input | 1 | Fetched instruction will write a register |
| idUndef | input | 1 | Decode stage found an undefined opcode |
| exArith | input | 1 | Execute stage raised an arithmetic fault |
| irqReq | input | 1 | External interrupt request, level |
| eretReq | input | 1 | Return from handler to the saved PC |
| memWrEn | output | 1 | Memory write allowed for the memory-stage instruction |
| memWrPc | output | PC_W | PC of the memory-stage instruction |
| regWrEn | output | 1 | Register write allowed for the write-back instruction |
| regWrPc | output | PC_W | PC of the write-back instruction |
| redirect | output | 1 | Fetch must be redirected this cycle |
| redirectPc | output | PC_W | Redirect target |
| epc | output | PC_W | Saved exception PC |
| cause | output | 2 | Saved cause: 0 interrupt, 1 undefined opcode, 2 arithmetic |

## Verification
An instruction fetched in cycle t can write memory in cycle t+3 and a register in cycle t+4. If it is taken, redirect appears in cycle t+3, and epc and cause hold the new values from cycle t+4. The bench's driver counts scenario cycles from the first fetch and queues each expected event with its absolute cycle number. A monitor samples at the falling edge and compares every queued item in exactly its due cycle. Any write or redirect that has no matching queued item is reported as a failure, so writes by younger instructions and early interrupt takes are caught in the cycle they occur.

// File: rtl/excPkg.sv
package excPkg;

  // Cause codes saved in the cause register
  typedef enum logic [1:0] {
    CAUSE_IRQ   = 2'd0,
    CAUSE_UNDEF = 2'd1,
    CAUSE_ARITH = 2'd2
  } causeT;

  // Strobes from the commit control to the tag datapath
  typedef struct packed {
    logic  take;       // exception taken on the memory-stage instruction
    logic  eret;       // return to saved PC
    causeT causeCode;  // code to record on take
  } strobeT;

endpackage

// File: rtl/excCommitCtrl.sv
module excCommitCtrl
  import excPkg::*;
(
  input  logic   memValid,
  input  logic   memExc,
  input  causeT  memCause,
  input  logic   irqReq,
  input  logic   eretReq,
  output strobeT strobe
);

  logic takeNow;

  // Decision is made only where architected state first changes
  assign takeNow = memValid & (memExc | irqReq);

  always_comb begin
    strobe           = '0;
    strobe.take      = takeNow;
    // a synchronous fault on the instruction outranks the interrupt
    strobe.causeCode = memExc ? memCause : CAUSE_IRQ;
    strobe.eret      = eretReq & ~takeNow;
  end

endmodule

// File: rtl/excTagPipe.sv
module excTagPipe
  import excPkg::*;
#(
  parameter int unsigned         PC_W        = 32,
  parameter logic [PC_W-1:0]     HANDLER_VEC = 32'h0000_0180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ifValid,
  input  logic [PC_W-1:0] ifPc,
  input  logic            ifMemWr,
  input  logic            ifRegWr,
  input  logic            idUndef,
  input  logic            exArith,
  input  strobeT          strobe,
  output logic            memValid,
  output logic            memExc,
  output causeT           memCause,
  output logic            memWrEn,
  output logic [PC_W-1:0] memWrPc,
  output logic            regWrEn,
  output logic [PC_W-1:0] regWrPc,
  output logic            redirect,
  output logic [PC_W-1:0] redirectPc,
  output logic [PC_W-1:0] epc,
  output causeT           cause
);

  // Stage slots: decode, execute, memory, write-back
  localparam int unsigned NSTG    = 4;
  localparam int unsigned ID_IDX  = 0;
  localparam int unsigned EX_IDX  = 1;
  localparam int unsigned MEM_IDX = 2;
  localparam int unsigned WB_IDX  = NSTG - 1;

  typedef struct packed {
    logic            valid;
    logic [PC_W-1:0] pc;
    logic            exc;
    causeT           cause;
    logic            memWr;
    logic            regWr;
  } stageT;

  stageT stg [NSTG];
  logic  faultHit  [NSTG];
  causeT faultCode [NSTG];

  // Fault detected while an instruction sits in a stage, tagged as it leaves
  always_comb begin
    for (int i = 0; i < NSTG; i++) begin
      faultHit[i]  = 1'b0;
      faultCode[i] = CAUSE_IRQ;
    end
    faultHit[ID_IDX]  = idUndef;
    faultCode[ID_IDX] = CAUSE_UNDEF;
    faultHit[EX_IDX]  = exArith;
    faultCode[EX_IDX] = CAUSE_ARITH;
  end

  // First recorded cause is kept; later detections do not overwrite it
  function automatic stageT tagStage(stageT s, logic hit, causeT code);
    stageT r;
    r = s;
    if (s.valid && hit && !s.exc) begin
      r.exc   = 1'b1;
      r.cause = code;
    end
    return r;
  endfunction

  // Fetch into decode slot; dropped on take or return
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg[0] <= '0;
    end else if (strobe.take || strobe.eret) begin
      stg[0] <= '0;
    end else begin
      stg[0].valid <= ifValid;
      stg[0].pc    <= ifPc;
      stg[0].exc   <= 1'b0;
      stg[0].cause <= CAUSE_IRQ;
      stg[0].memWr <= ifMemWr;
      stg[0].regWr <= ifRegWr;
    end
  end

  // Remaining slots: shift down, all cleared on take
  for (genvar g = 1; g < NSTG; g++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg[g] <= '0;
      end else if (strobe.take) begin
        stg[g] <= '0;
      end else begin
        stg[g] <= tagStage(stg[g-1], faultHit[g-1], faultCode[g-1]);
      end
    end
  end

  // Saved PC and cause
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc   <= '0;
      cause <= CAUSE_IRQ;
    end else if (strobe.take) begin
      epc   <= stg[MEM_IDX].pc;
      cause <= strobe.causeCode;
    end
  end

  assign memValid   = stg[MEM_IDX].valid;
  assign memExc     = stg[MEM_IDX].exc;
  assign memCause   = stg[MEM_IDX].cause;
  assign memWrEn    = stg[MEM_IDX].valid & stg[MEM_IDX].memWr & ~strobe.take;
  assign memWrPc    = stg[MEM_IDX].pc;
  assign regWrEn    = stg[WB_IDX].valid & stg[WB_IDX].regWr;
  assign regWrPc    = stg[WB_IDX].pc;
  assign redirect   = strobe.take | strobe.eret;
  assign redirectPc = strobe.take ? HANDLER_VEC : epc;

  // R5
  flushMem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.take |=> !stg[MEM_IDX].valid);

  // R5
  killWb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.take |=> !regWrEn);

  // R3
  epcLoad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.take |=> (epc == $past(memWrPc)) && (cause == $past(strobe.causeCode)));

  // R11
  holdState_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.take |=> $stable(epc) && $stable(cause));

  // R12
  eretFlush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.eret |=> !stg[ID_IDX].valid);

  // R9
  irqWait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stg[MEM_IDX].valid |-> !strobe.take);

endmodule

// File: rtl/precExcCommit.sv
module precExcCommit
  import excPkg::*;
#(
  parameter int unsigned     PC_W        = 32,
  parameter logic [PC_W-1:0] HANDLER_VEC = 32'h0000_0180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ifValid,
  input  logic [PC_W-1:0] ifPc,
  input  logic            ifMemWr,
  input  logic            ifRegWr,
  input  logic            idUndef,
  input  logic            exArith,
  input  logic            irqReq,
  input  logic            eretReq,
  output logic            memWrEn,
  output logic [PC_W-1:0] memWrPc,
  output logic            regWrEn,
  output logic [PC_W-1:0] regWrPc,
  output logic            redirect,
  output logic [PC_W-1:0] redirectPc,
  output logic [PC_W-1:0] epc,
  output logic [1:0]      cause
);

  strobeT strobe;
  logic   memValid;
  logic   memExc;
  causeT  memCause;
  causeT  causeReg;

  excCommitCtrl uCtrl (
    .memValid (memValid),
    .memExc   (memExc),
    .memCause (memCause),
    .irqReq   (irqReq),
    .eretReq  (eretReq),
    .strobe   (strobe)
  );

  excTagPipe #(
    .PC_W        (PC_W),
    .HANDLER_VEC (HANDLER_VEC)
  ) uPipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .ifValid    (ifValid),
    .ifPc       (ifPc),
    .ifMemWr    (ifMemWr),
    .ifRegWr    (ifRegWr),
    .idUndef    (idUndef),
    .exArith    (exArith),
    .strobe     (strobe),
    .memValid   (memValid),
    .memExc     (memExc),
    .memCause   (memCause),
    .memWrEn    (memWrEn),
    .memWrPc    (memWrPc),
    .regWrEn    (regWrEn),
    .regWrPc    (regWrPc),
    .redirect   (redirect),
    .redirectPc (redirectPc),
    .epc        (epc),
    .cause      (causeReg)
  );

  assign cause = causeReg;

endmodule

// File: tb/sim_precExcCommit.sv
`timescale 1ns/1ps
module sim_precExcCommit;

  localparam int unsigned PC_W    = 32;
  localparam logic [31:0] HANDLER = 32'h0000_0180;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ifValid = 1'b0, ifMemWr = 1'b0, ifRegWr = 1'b0;
  logic [PC_W-1:0] ifPc = '0;
  logic idUndef = 1'b0, exArith = 1'b0, irqReq = 1'b0, eretReq = 1'b0;
  logic memWrEn, regWrEn, redirect;
  logic [PC_W-1:0] memWrPc, regWrPc, redirectPc, epc;
  logic [1:0] cause;

  always #2.5 clk = ~clk;

  precExcCommit #(.PC_W(PC_W), .HANDLER_VEC(HANDLER)) u0 (
    .clk(clk), .rst_n(rst_n), .ifValid(ifValid), .ifPc(ifPc),
    .ifMemWr(ifMemWr), .ifRegWr(ifRegWr), .idUndef(idUndef),
    .exArith(exArith), .irqReq(irqReq), .eretReq(eretReq),
    .memWrEn(memWrEn), .memWrPc(memWrPc), .regWrEn(regWrEn),
    .regWrPc(regWrPc), .redirect(redirect), .redirectPc(redirectPc),
    .epc(epc), .cause(cause)
  );

  typedef struct {
    int    cyc;
    int    kind;   // 0 mem write, 1 reg write, 2 redirect, 3 saved state
    int    val;
    int    val2;
    string tag;
  } itemT;

  itemT  q[$];
  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    monOn = 1'b0;
  bit    done = 1'b0;
  string curTag = "";
  int    lastEpc = 0;
  int    lastCause = 0;

  // per-instruction program: fault 0 none, 1 undef, 2 arith, 3 both
  int progFault [8];
  int progMw    [8];
  int progRw    [8];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic push(input int c, input int k, input int v, input int v2, input string t);
    itemT it;
    it.cyc = c; it.kind = k; it.val = v; it.val2 = v2; it.tag = t;
    q.push_back(it);
  endtask

  // Monitor: compares due items at the falling edge, flags stray events
  always @(negedge clk) begin
    if (monOn) begin
      bit oMem, oReg, oRed;
      oMem = memWrEn; oReg = regWrEn; oRed = redirect;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        itemT it;
        it = q.pop_front();
        case (it.kind)
          0: begin
            chk(oMem && memWrPc == it.val, {it.tag, " mem write"}, oMem ? int'(memWrPc) : -1, it.val);
            oMem = 1'b0;
          end
          1: begin
            chk(oReg && regWrPc == it.val, {it.tag, " reg write"}, oReg ? int'(regWrPc) : -1, it.val);
            oReg = 1'b0;
          end
          2: begin
            chk(oRed && redirectPc == it.val, {it.tag, " redirect"}, oRed ? int'(redirectPc) : -1, it.val);
            oRed = 1'b0;
          end
          default: begin
            chk(epc == it.val, {it.tag, " epc"}, int'(epc), it.val);
            chk(int'(cause) == it.val2, {it.tag, " cause"}, int'(cause), it.val2);
          end
        endcase
      end
      if (oMem) chk(1'b0, {curTag, " R5 stray mem write"}, int'(memWrPc), -1);
      if (oReg) chk(1'b0, {curTag, " R5 stray reg write"}, int'(regWrPc), -1);
      if (oRed) chk(1'b0, {curTag, " R9 stray redirect"}, int'(redirectPc), -1);
    end
  end

  task automatic idle();
    ifValid = 0; ifMemWr = 0; ifRegWr = 0; ifPc = '0;
    idUndef = 0; exArith = 0; irqReq = 0; eretReq = 0;
  endtask

  // Runs n instructions fetched back to back; irqAt < 0 means no interrupt
  task automatic runProg(input int n, input int pcBase, input int irqAt, input string tag);
    int j, base, lastF, jc, errBefore;
    j = -1;
    for (int k = 0; k < n; k++)
      if (j < 0 && (progFault[k] != 0 || (irqAt >= 0 && k + 3 >= irqAt))) j = k;
    jc = 0;
    if (j >= 0) jc = (progFault[j] == 3) ? 1 : progFault[j];
    base = cyc;
    curTag = tag;
    errBefore = errors;
    for (int c = 0; c <= n + 5; c++) begin
      if (c - 3 >= 0 && c - 3 < n && (j < 0 || c - 3 < j) && progMw[c-3] != 0)
        push(base + c, 0, pcBase + 4 * (c - 3), 0, {tag, " R2"});
      if (c - 4 >= 0 && c - 4 < n && (j < 0 || c - 4 < j) && progRw[c-4] != 0)
        push(base + c, 1, pcBase + 4 * (c - 4), 0, {tag, " R2 R6"});
      if (j >= 0 && c == j + 3)
        push(base + c, 2, HANDLER, 0, tag);
      if (j >= 0 && c == j + 4)
        push(base + c, 3, pcBase + 4 * j, jc, tag);
      if (j < 0 && c == n + 4)
        push(base + c, 3, lastEpc, lastCause, {tag, " R11 hold"});
    end
    lastF = (j >= 0 && j + 3 < n - 1) ? j + 3 : n - 1;
    for (int t = 0; t <= n + 6; t++) begin
      ifValid = (t <= lastF);
      ifPc    = pcBase + 4 * t;
      ifMemWr = (t < n) ? (progMw[t] != 0) : 1'b0;
      ifRegWr = (t < n) ? (progRw[t] != 0) : 1'b0;
      idUndef = (t >= 1 && t - 1 < n) ? (progFault[t-1] == 1 || progFault[t-1] == 3) : 1'b0;
      exArith = (t >= 2 && t - 2 < n) ? (progFault[t-2] == 2 || progFault[t-2] == 3) : 1'b0;
      irqReq  = (irqAt >= 0 && t >= irqAt && (j < 0 || t <= j + 3));
      @(posedge clk); #1;
    end
    idle();
    if (j >= 0) begin
      lastEpc = pcBase + 4 * j;
      lastCause = jc;
    end
    chk(errors == errBefore, {tag, " R5 scenario clean"}, errors - errBefore, 0);
  endtask

  task automatic setProg(input int n, input int mw, input int rw);
    for (int k = 0; k < 8; k++) begin
      progFault[k] = 0;
      progMw[k] = (k < n) ? mw : 0;
      progRw[k] = (k < n) ? rw : 0;
    end
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(memWrEn == 0 && regWrEn == 0 && redirect == 0, "R1 write enables after reset",
        {memWrEn, regWrEn, redirect}, 0);
    chk(epc == 0 && cause == 0, "R1 saved state after reset", int'(epc) + int'(cause), 0);
    @(posedge clk); #1;
    monOn = 1'b1;

    // R2 fault-free stream with mixed write intents
    setProg(4, 1, 1);
    progMw[1] = 0; progRw[2] = 0;
    runProg(4, 32'h1000, -1, "R2");

    // R3 undefined opcode in decode, R5 younger writes suppressed
    setProg(6, 1, 1);
    progFault[2] = 1;
    runProg(6, 32'h2000, -1, "R3");

    // R4 arithmetic fault, R6 older write in take cycle
    setProg(5, 1, 1);
    progFault[1] = 2;
    runProg(5, 32'h3000, -1, "R4");

    // R7 faults on two instructions flagged in the same cycle
    setProg(6, 1, 1);
    progFault[2] = 2; progFault[3] = 1;
    runProg(6, 32'h4000, -1, "R7");

    // R8 both detections on one instruction keep the first cause
    setProg(5, 1, 1);
    progFault[1] = 3;
    runProg(5, 32'h5000, -1, "R8");

    // R9 interrupt raised while memory stage still empty
    setProg(5, 1, 1);
    runProg(5, 32'h6000, 0, "R9");

    // R10 fault and interrupt on the same memory-stage instruction
    setProg(6, 1, 1);
    progFault[1] = 2;
    runProg(6, 32'h7000, 4, "R10");

    // R11 fault-free run leaves saved state unchanged
    setProg(3, 0, 1);
    runProg(3, 32'h8000, -1, "R11");

    // R12 return redirects to saved PC and drops the same-cycle fetch
    begin
      int base;
      base = cyc;
      curTag = "R12";
      push(base, 2, lastEpc, 0, "R12 return");
      eretReq = 1; ifValid = 1; ifPc = 32'h9000; ifMemWr = 1; ifRegWr = 1;
      @(posedge clk); #1;
      idle();
      repeat (7) @(posedge clk);
      #1;
      chk(q.size() == 0, "R12 queue drained", q.size(), 0);
    end

    monOn = 1'b0;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule